// File: doc/BRIEF.md
# Abstract Register-Access Instruction Generator

This block sits in a debug controller between the command register and the small instruction buffer that a halted hart runs on request. When a start strobe arrives with an access-register command word, the block checks the command and works out which register class the register number selects: a CSR, an integer register or a floating-point register. It then writes a short sequence of real 32-bit RISC-V instruction words into the buffer, one word per clock, from address 0 upward. The words move a value between that register and a fixed data area in memory. Memory is addressed through x0 plus a 12-bit immediate, so the data-area address must fit in a signed 12-bit value.

The sequence always ends with one of two words. If the command asks to continue into the program buffer, the last word is a jump there. Otherwise it is a breakpoint that hands control back to the debug loop. A command that cannot be carried out writes nothing. It raises done for one cycle together with an error code, which the command-status logic records.

The block is a three-state machine. IDLE waits for start. IDLE goes to EMIT when the command is accepted, and to FAIL when it is refused. EMIT writes one word per cycle and goes back to IDLE after the final word. FAIL lasts one cycle, reports the error, and goes back to IDLE.

Top module: `abs_regaccess_gen`

## Requirements
- R1: A command whose type field (bits 31:24) is not zero writes no word and raises done with error code 2 (unsupported) in the cycle after start.
- R2: With type zero and halted_i low, the command writes nothing and reports error code 4 (hart not halted). The type check takes precedence over the halted check.
- R3: With the transfer flag (bit 17) clear, the sequence is the single final word at address 0, whatever the size and register number.
- R4: A register number from 0x1000 to 0x101F selects integer register regno−0x1000. With the write flag (bit 16) set, the block emits a load from DATA_ADDR(x0) into that register. With the write flag clear, it emits a store of that register to DATA_ADDR(x0). The final word follows.
- R5: A register number from 0x1020 to 0x103F selects floating-point register regno−0x1020. The block emits a floating-point load (opcode 0x07) or store (opcode 0x27) in the same way.
- R6: A register number below 0x1000 is a CSR. Writing a CSR emits a load of x8 from the data area, then csrrw x0,csr,x8. Reading a CSR emits csrrs x8,csr,x0, then a store of x8 to the data area.
- R7: When PROGBUF_WORDS is below 2, a CSR access first saves x8 to CSR 0x7B2 (csrrw x0,0x7B2,x8) and restores it (csrrs x8,0x7B2,x0) just before the final word.
- R8: The size field is bits 22:20. Code 2 selects word accesses (funct3 010) and code 3 selects doubleword accesses (funct3 011). Any other code, with transfer set, gives error 2.
- R9: With transfer set, a register number of 0x1040 or above gives error 2.
- R10: The final word is 0x00100073 (ebreak). When the postexec flag (bit 18) is set, it is instead jal x0 with offset PBUF_OFFSET − 4·k, where k is that word's buffer address.
- R11: After reset the outputs are idle. An accepted command writes its first word at address 0 in the cycle after start. It then writes one word per cycle at consecutive addresses. Done is high for exactly one cycle, the cycle of the final word, with error 0.
- R12: A start pulse while a sequence is being written is ignored. The running sequence is not changed and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command strobe, sampled only in IDLE |
| cmd_i | input | 32 | Access-register command word |
| halted_i | input | 1 | Selected hart is halted |
| wr_en_o | output | 1 | Instruction-buffer write enable |
| wr_addr_o | output | AW (3) | Instruction-buffer word address |
| wr_data_o | output | 32 | Instruction word to write |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 3 | Error code, valid with done_o (0 ok, 2 unsupported, 4 not halted) |

## Verification
The save and restore of x8 around a CSR access cannot be reached from the ports of an instance whose program buffer holds two or more words. The bench therefore drives the same command stream into a second instance built with a one-word program buffer and models both at once. The same stream gives jump offsets at several tail positions, from the one-word sequence up to the five-word sequence. The ignored-start case is reached by pulsing start, with a refusable command, in the middle of the longest sequence.

// File: rtl/abs_gen_pkg.sv
package abs_gen_pkg;

    typedef enum logic [3:0] {
        ST_TAIL,
        ST_SAVE_S0,
        ST_RESTORE_S0,
        ST_LD_S0,
        ST_ST_S0,
        ST_CSR_WR,
        ST_CSR_RD,
        ST_LD_GPR,
        ST_ST_GPR,
        ST_LD_FPR,
        ST_ST_FPR
    } step_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EMIT,
        S_FAIL
    } fsm_e;

    localparam int MAX_STEPS = 5;
    localparam int CW        = $clog2(MAX_STEPS);

    localparam logic [2:0] ERR_NONE       = 3'd0;
    localparam logic [2:0] ERR_NOTSUP     = 3'd2;
    localparam logic [2:0] ERR_HALTRESUME = 3'd4;

    localparam logic [4:0]  REG_S0       = 5'd8;
    localparam logic [11:0] CSR_DSCRATCH = 12'h7B2;

    localparam logic [6:0] OP_LOAD   = 7'b0000011;
    localparam logic [6:0] OP_STORE  = 7'b0100011;
    localparam logic [6:0] OP_FLOAD  = 7'b0000111;
    localparam logic [6:0] OP_FSTORE = 7'b0100111;
    localparam logic [6:0] OP_SYSTEM = 7'b1110011;
    localparam logic [6:0] OP_JAL    = 7'b1101111;

    localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;

endpackage

// File: rtl/abs_cmd_decode.sv
module abs_cmd_decode
    import abs_gen_pkg::*;
#(
    parameter int PROGBUF_WORDS = 2
) (
    input  logic [31:0]                 cmd_i,
    input  logic                        halted_i,
    output step_e [MAX_STEPS-1:0]       steps_o,
    output logic  [CW-1:0]              last_o,
    output logic  [2:0]                 err_o
);

    localparam bit SAVE_S0 = (PROGBUF_WORDS < 2);

    logic [7:0]  cmd_type;
    logic [2:0]  size_code;
    logic        xfer;
    logic        wr;
    logic [15:0] regno;
    logic        unused_bits;

    assign cmd_type    = cmd_i[31:24];
    assign size_code   = cmd_i[22:20];
    assign xfer        = cmd_i[17];
    assign wr          = cmd_i[16];
    assign regno       = cmd_i[15:0];
    assign unused_bits = ^{cmd_i[23], cmd_i[19], cmd_i[18]};

    always_comb begin
        int n;
        n = 0;
        err_o = ERR_NONE;
        for (int k = 0; k < MAX_STEPS; k++) steps_o[k] = ST_TAIL;

        if (cmd_type != 8'd0) begin
            err_o = ERR_NOTSUP;
        end else if (!halted_i) begin
            err_o = ERR_HALTRESUME;
        end else if (xfer) begin
            if (size_code != 3'd2 && size_code != 3'd3) begin
                err_o = ERR_NOTSUP;
            end else if (regno < 16'h1000) begin
                if (SAVE_S0) begin
                    steps_o[n] = ST_SAVE_S0;
                    n++;
                end
                if (wr) begin
                    steps_o[n] = ST_LD_S0;
                    n++;
                    steps_o[n] = ST_CSR_WR;
                    n++;
                end else begin
                    steps_o[n] = ST_CSR_RD;
                    n++;
                    steps_o[n] = ST_ST_S0;
                    n++;
                end
                if (SAVE_S0) begin
                    steps_o[n] = ST_RESTORE_S0;
                    n++;
                end
            end else if (regno < 16'h1020) begin
                if (wr) steps_o[n] = ST_LD_GPR;
                else    steps_o[n] = ST_ST_GPR;
                n++;
            end else if (regno < 16'h1040) begin
                if (wr) steps_o[n] = ST_LD_FPR;
                else    steps_o[n] = ST_ST_FPR;
                n++;
            end else begin
                err_o = ERR_NOTSUP;
            end
        end
        last_o = CW'(n);
    end

endmodule

// File: rtl/abs_insn_encode.sv
module abs_insn_encode
    import abs_gen_pkg::*;
#(
    parameter int DATA_ADDR   = 'h380,
    parameter int PBUF_OFFSET = 32
) (
    input  step_e          step_i,
    input  logic [11:0]    regsel_i,
    input  logic           dbl_i,
    input  logic [CW-1:0]  idx_i,
    input  logic           postexec_i,
    output logic [31:0]    word_o
);

    localparam logic [11:0] DA = 12'(DATA_ADDR);

    logic [2:0]  f3;
    logic [4:0]  rn;
    logic [20:0] joff;

    assign f3   = dbl_i ? 3'b011 : 3'b010;
    assign rn   = regsel_i[4:0];
    assign joff = 21'(PBUF_OFFSET - 4 * int'(idx_i));

    always_comb begin
        word_o = INSN_EBREAK;
        unique case (step_i)
            ST_TAIL:
                if (postexec_i)
                    word_o = {joff[20], joff[10:1], joff[11], joff[19:12], 5'd0, OP_JAL};
            ST_SAVE_S0:    word_o = {CSR_DSCRATCH, REG_S0, 3'b001, 5'd0, OP_SYSTEM};
            ST_RESTORE_S0: word_o = {CSR_DSCRATCH, 5'd0, 3'b010, REG_S0, OP_SYSTEM};
            ST_LD_S0:      word_o = {DA, 5'd0, f3, REG_S0, OP_LOAD};
            ST_ST_S0:      word_o = {DA[11:5], REG_S0, 5'd0, f3, DA[4:0], OP_STORE};
            ST_CSR_WR:     word_o = {regsel_i, REG_S0, 3'b001, 5'd0, OP_SYSTEM};
            ST_CSR_RD:     word_o = {regsel_i, 5'd0, 3'b010, REG_S0, OP_SYSTEM};
            ST_LD_GPR:     word_o = {DA, 5'd0, f3, rn, OP_LOAD};
            ST_ST_GPR:     word_o = {DA[11:5], rn, 5'd0, f3, DA[4:0], OP_STORE};
            ST_LD_FPR:     word_o = {DA, 5'd0, f3, rn, OP_FLOAD};
            ST_ST_FPR:     word_o = {DA[11:5], rn, 5'd0, f3, DA[4:0], OP_FSTORE};
            default:       word_o = INSN_EBREAK;
        endcase
    end

endmodule

// File: rtl/abs_regaccess_gen.sv
module abs_regaccess_gen
    import abs_gen_pkg::*;
#(
    parameter int PROGBUF_WORDS = 2,
    parameter int ABS_WORDS     = 8,
    parameter int DATA_ADDR     = 'h380,
    parameter int PBUF_OFFSET   = 32,
    localparam int AW           = $clog2(ABS_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [31:0]   cmd_i,
    input  logic          halted_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [31:0]   wr_data_o,
    output logic          done_o,
    output logic [2:0]    err_o
);

    fsm_e                  state_q;
    logic  [CW-1:0]        idx_q;
    logic  [CW-1:0]        last_q;
    step_e [MAX_STEPS-1:0] steps_q;
    logic  [11:0]          regsel_q;
    logic                  dbl_q;
    logic                  post_q;
    logic  [2:0]           err_q;

    step_e [MAX_STEPS-1:0] dec_steps;
    logic  [CW-1:0]        dec_last;
    logic  [2:0]           dec_err;

    abs_cmd_decode #(
        .PROGBUF_WORDS(PROGBUF_WORDS)
    ) dec_i (
        .cmd_i    (cmd_i),
        .halted_i (halted_i),
        .steps_o  (dec_steps),
        .last_o   (dec_last),
        .err_o    (dec_err)
    );

    abs_insn_encode #(
        .DATA_ADDR  (DATA_ADDR),
        .PBUF_OFFSET(PBUF_OFFSET)
    ) enc_i (
        .step_i     (steps_q[idx_q]),
        .regsel_i   (regsel_q),
        .dbl_i      (dbl_q),
        .idx_i      (idx_q),
        .postexec_i (post_q),
        .word_o     (wr_data_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            idx_q    <= '0;
            last_q   <= '0;
            regsel_q <= '0;
            dbl_q    <= 1'b0;
            post_q   <= 1'b0;
            err_q    <= ERR_NONE;
            for (int k = 0; k < MAX_STEPS; k++) steps_q[k] <= ST_TAIL;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        if (dec_err != ERR_NONE) begin
                            state_q <= S_FAIL;
                            err_q   <= dec_err;
                        end else begin
                            state_q  <= S_EMIT;
                            idx_q    <= '0;
                            last_q   <= dec_last;
                            steps_q  <= dec_steps;
                            regsel_q <= cmd_i[11:0];
                            dbl_q    <= cmd_i[20];
                            post_q   <= cmd_i[18];
                        end
                    end
                end
                S_EMIT: begin
                    if (idx_q == last_q) state_q <= S_IDLE;
                    else                 idx_q   <= idx_q + 1'b1;
                end
                S_FAIL:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_en_o   = 1'b0;
        wr_addr_o = '0;
        done_o    = 1'b0;
        err_o     = ERR_NONE;
        unique case (state_q)
            S_IDLE: ;
            S_EMIT: begin
                wr_en_o   = 1'b1;
                wr_addr_o = AW'(idx_q);
                done_o    = (idx_q == last_q);
            end
            S_FAIL: begin
                done_o = 1'b1;
                err_o  = err_q;
            end
            default: ;
        endcase
    end

    assert_err_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o != ERR_NONE) |-> (done_o && !wr_en_o));

    assert_halt_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == ERR_HALTRESUME) |-> $past(!halted_i));

    assert_tail_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == ERR_NONE) |->
            (wr_en_o && (wr_data_o == INSN_EBREAK || wr_data_o[6:0] == OP_JAL)));

    assert_addr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !done_o) |=> (wr_en_o && wr_addr_o == $past(wr_addr_o) + 1'b1));

    assert_first_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en_o) |-> (wr_addr_o == '0));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/abs_regaccess_gen_tb_top.sv
module abs_regaccess_gen_tb_top;

    localparam int DA    = 'h380;
    localparam int POFF  = 32;
    localparam int AW    = 3;

    typedef struct {
        bit          we;
        int          addr;
        logic [31:0] data;
        bit          done;
        int          err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cmd = '0;
    logic        halted = 1'b1;

    logic          m_we, l_we, m_done, l_done;
    logic [AW-1:0] m_addr, l_addr;
    logic [31:0]   m_data, l_data;
    logic [2:0]    m_err, l_err;

    exp_t  q_main[$];
    exp_t  q_lite[$];
    string cur_tag = "R11";
    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;

    always #5 clk = ~clk;

    abs_regaccess_gen #(.PROGBUF_WORDS(2), .ABS_WORDS(8), .DATA_ADDR(DA), .PBUF_OFFSET(POFF)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .halted_i(halted),
        .wr_en_o(m_we), .wr_addr_o(m_addr), .wr_data_o(m_data), .done_o(m_done), .err_o(m_err));

    abs_regaccess_gen #(.PROGBUF_WORDS(1), .ABS_WORDS(8), .DATA_ADDR(DA), .PBUF_OFFSET(POFF)) dut_lite_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .halted_i(halted),
        .wr_en_o(l_we), .wr_addr_o(l_addr), .wr_data_o(l_data), .done_o(l_done), .err_o(l_err));

    function automatic logic [31:0] mk(int typ, int sz, bit pe, bit xf, bit wr, int rn);
        return {8'(typ), 1'b0, 3'(sz), 1'b0, pe, xf, wr, 16'(rn)};
    endfunction

    function automatic logic [31:0] i_w(int imm, int rs1, int f3, int rd, int op);
        return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), 7'(op)};
    endfunction

    function automatic logic [31:0] s_w(int imm, int rs2, int rs1, int f3, int op);
        logic [11:0] im;
        im = 12'(imm);
        return {im[11:5], 5'(rs2), 5'(rs1), 3'(f3), im[4:0], 7'(op)};
    endfunction

    function automatic logic [31:0] jal_w(int off);
        logic [20:0] o;
        o = 21'(off);
        return {o[20], o[10:1], o[11], o[19:12], 5'd0, 7'h6f};
    endfunction

    // Behavioural reference: builds the expected per-cycle output list
    task automatic model(input logic [31:0] c, input bit h, input int pbw, input bit lite, input string tag);
        logic [31:0] w[$];
        int errc, f3, rn, sz;
        bit save;
        exp_t e;
        errc = 0;
        sz = int'(c[22:20]);
        rn = int'(c[15:0]);
        f3 = (sz == 3) ? 3 : 2;
        if (c[31:24] != 0) errc = 2;
        else if (!h) errc = 4;
        else if (c[17]) begin
            if (sz != 2 && sz != 3) errc = 2;
            else if (rn < 'h1000) begin
                save = (pbw < 2);
                if (save) w.push_back(i_w('h7b2, 8, 1, 0, 'h73));
                if (c[16]) begin
                    w.push_back(i_w(DA, 0, f3, 8, 'h03));
                    w.push_back(i_w(rn, 8, 1, 0, 'h73));
                end else begin
                    w.push_back(i_w(rn, 0, 2, 8, 'h73));
                    w.push_back(s_w(DA, 8, 0, f3, 'h23));
                end
                if (save) w.push_back(i_w('h7b2, 0, 2, 8, 'h73));
            end else if (rn < 'h1020) begin
                if (c[16]) w.push_back(i_w(DA, 0, f3, rn - 'h1000, 'h03));
                else       w.push_back(s_w(DA, rn - 'h1000, 0, f3, 'h23));
            end else if (rn < 'h1040) begin
                if (c[16]) w.push_back(i_w(DA, 0, f3, rn - 'h1020, 'h07));
                else       w.push_back(s_w(DA, rn - 'h1020, 0, f3, 'h27));
            end else errc = 2;
        end
        if (errc != 0) begin
            e = '{we: 0, addr: 0, data: 0, done: 1, err: errc, tag: tag};
            if (lite) q_lite.push_back(e); else q_main.push_back(e);
        end else begin
            if (c[18]) w.push_back(jal_w(POFF - 4 * w.size()));
            else       w.push_back(32'h0010_0073);
            foreach (w[k]) begin
                e = '{we: 1, addr: k, data: w[k], done: (k == w.size() - 1), err: 0, tag: tag};
                if (lite) q_lite.push_back(e); else q_main.push_back(e);
            end
        end
    endtask

    task automatic compare(input bit lite);
        exp_t e;
        bit we, dn, bad;
        logic [AW-1:0] ad;
        logic [31:0] dt;
        logic [2:0] er;
        we = lite ? l_we : m_we;
        dn = lite ? l_done : m_done;
        ad = lite ? l_addr : m_addr;
        dt = lite ? l_data : m_data;
        er = lite ? l_err : m_err;
        if (lite ? (q_lite.size() > 0) : (q_main.size() > 0))
            e = lite ? q_lite.pop_front() : q_main.pop_front();
        else
            e = '{we: 0, addr: 0, data: 0, done: 0, err: 0, tag: cur_tag};
        checks++;
        bad = (we != e.we) || (dn != e.done) || (int'(er) != e.err);
        if (e.we && (int'(ad) != e.addr || dt != e.data)) bad = 1;
        if (bad) begin
            failures++;
            $display("FAIL %s dut=%s actual we=%0b addr=%0d data=%08h done=%0b err=%0d expected we=%0b addr=%0d data=%08h done=%0b err=%0d",
                     e.tag, lite ? "lite" : "main", we, ad, dt, dn, er, e.we, e.addr, e.data, e.done, e.err);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            if (rst_n) begin
                compare(0);
                compare(1);
            end
            if (cyc > 20000) begin
                failures++;
                $display("FAIL R11 watchdog expired actual cycles=%0d expected below 20000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    task automatic run(input logic [31:0] c, input bit h, input string tag);
        @(negedge clk);
        cur_tag = tag;
        cmd = c;
        halted = h;
        start = 1'b1;
        model(c, h, 2, 0, tag);
        model(c, h, 1, 1, tag);
        @(negedge clk);
        start = 1'b0;
        while (q_main.size() > 0 || q_lite.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R11 reset";
        repeat (2) @(negedge clk);

        run(mk(1, 2, 0, 1, 1, 'h1005), 1, "R1");
        run(mk(8'h80, 2, 1, 0, 0, 'h0), 1, "R1");
        run(mk(0, 2, 0, 1, 1, 'h1005), 0, "R2");
        run(mk(2, 2, 0, 1, 1, 'h1005), 0, "R2");
        run(mk(0, 2, 0, 0, 0, 'h9999), 1, "R3");
        run(mk(0, 5, 0, 0, 1, 'hffff), 1, "R3 R8");
        run(mk(0, 2, 1, 0, 0, 'h0), 1, "R10");
        run(mk(0, 2, 0, 1, 1, 'h1005), 1, "R4");
        run(mk(0, 3, 1, 1, 0, 'h101f), 1, "R4 R10");
        run(mk(0, 3, 0, 1, 1, 'h1023), 1, "R5");
        run(mk(0, 2, 1, 1, 0, 'h1020), 1, "R5");
        run(mk(0, 2, 1, 1, 1, 'h300), 1, "R6 R7");
        run(mk(0, 3, 0, 1, 0, 'h7b0), 1, "R6 R7");
        run(mk(0, 3, 1, 1, 0, 'hfff), 1, "R6 R7 R10");
        run(mk(0, 1, 0, 1, 1, 'h1001), 1, "R8");
        run(mk(0, 4, 0, 1, 0, 'h300), 1, "R8");
        run(mk(0, 2, 0, 1, 1, 'h1040), 1, "R9");
        run(mk(0, 3, 0, 1, 0, 'hffff), 1, "R9");

        // R12: second start in the middle of a five-word sequence
        @(negedge clk);
        cur_tag = "R12";
        cmd = mk(0, 2, 1, 1, 0, 'h341);
        halted = 1'b1;
        start = 1'b1;
        model(cmd, 1'b1, 2, 0, "R12");
        model(cmd, 1'b1, 1, 1, "R12");
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        cmd = mk(1, 2, 0, 1, 1, 'h1002);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (q_main.size() > 0 || q_lite.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule